// File: doc/BRIEF.md
# Suspendable SDRAM Burst Datapath

This block is the memory-side data engine of a synchronous DRAM model with a 32-bit data bus. A command picks a direction (read or write) and a starting column. The block then runs a four-beat burst against a small internal word array. Write beats are taken from the write bus and stored. Read beats are driven onto the read bus one cycle after the beat's internal clock.

The clock-enable input can suspend a burst. A change on that pin takes effect one clock later. While the block is suspended, the beat counter holds, the read bus keeps showing its last word, and any write data on the bus is dropped. A burst therefore runs for four effective cycles, however many cycles that takes in total.

Commands use a valid/ready pair. `cmd_ready` is high whenever no burst is running. A command offered while `cmd_ready` is low is not accepted and raises an error pulse. The write stream has no ready signal and no back-pressure: the block takes one beat per effective cycle whether or not `wr_valid` is high. A beat that arrives with `wr_valid` low uses up its address without writing it. The read stream marks its data with `rd_valid`.

Top module: `sdr_burst_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rd_valid`, `burst_done` and `cmd_err` are 0. All 16 words of the array read back as zero.
- R2: The effective enable is `cke_in` registered once. Driving `cke_in` low in cycle k suspends cycle k+1.
- R3: During a read burst, a suspended cycle does not advance the beat counter. The next effective beat reads the address that follows the last word that was delivered.
- R4: During a read burst, the read bus and `rd_valid` keep their previous values through every suspended cycle.
- R5: During a write burst, the word on `wr_data` in a suspended cycle is not stored, and the beat counter holds.
- R6: A burst with start column C visits four columns whose upper bits equal C[3:2]. Their low two bits are C[1:0], C[1:0]+1, C[1:0]+2 and C[1:0]+3, taken modulo 4. Each effective write cycle stores `wr_data` at the next column in that order.
- R7: When `cmd_valid` is 1 while a burst runs, `cmd_err` is 1 in the next cycle. The running burst goes on unchanged in direction, column and data.
- R8: `burst_done` is 1 for exactly one cycle, the cycle that follows the clock edge that completes the fourth effective beat. `cmd_ready` returns to 1 in that same cycle.
- R9: An effective write cycle with `wr_valid` at 0 uses up its column, and that column keeps its old contents.
- R10: An accepted read places the word of effective beat n on `rd_data`, with `rd_valid` at 1, in the cycle after the edge that executes that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_in | input | 1 | Clock enable pin. It takes effect one cycle later. |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | High when idle; a command is accepted when valid and ready are both high |
| cmd_write | input | 1 | Command direction: 1 is write, 0 is read |
| cmd_col | input | 4 | Start column of the burst |
| wr_valid | input | 1 | Write beat carries data to store |
| wr_data | input | 32 | Write beat data |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 32 | Read beat data |
| burst_done | output | 1 | One-cycle pulse after the fourth effective beat |
| cmd_err | output | 1 | One-cycle pulse after a command is offered during a burst |

## Verification
A command is accepted at edge 0, and its first beat runs at edge 1 if the enable level driven before edge 0 was high. Every later beat runs one edge after the level that enables it. Write data and read results, `burst_done`, `cmd_ready` and `cmd_err` all change at the edge that executes the beat or sees the command. The bench drives and samples one nanosecond after each rising edge. It drives the enable pin one slot ahead of its data. It keeps its own count of effective beats, so each expected value is compared in the cycle that count says. Stored data is checked through later read bursts.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } burst_dir_e;
endpackage

// File: rtl/sdr_cke_sync.sv
module sdr_cke_sync #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_in,
  output logic cke_eff
);
  // one register stage gives the one-clock enable latency
  always_ff @(posedge clk) begin
    if (!rst_n) cke_eff <= RESET_LEVEL;
    else        cke_eff <= cke_in;
  end
endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_burst_pkg::*;
#(
  parameter int COL_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_eff,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  output logic             busy,
  output logic             beat_fire,
  output burst_dir_e       beat_dir,
  output logic [COL_W-1:0] beat_col,
  output logic             done_q,
  output logic             err_q
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic [BEAT_W-1:0] cnt_q;
  logic [COL_W-1:0]  base_q;
  burst_dir_e        dir_q;
  logic              last_beat;
  logic [BEAT_W-1:0] low_col;

  assign beat_fire = busy && cke_eff;
  assign last_beat = (cnt_q == BEAT_W'(BURST_LEN - 1));
  assign beat_dir  = dir_q;
  assign low_col   = base_q[BEAT_W-1:0] + cnt_q;

  generate
    if (COL_W > BEAT_W) begin : g_grouped
      assign beat_col = {base_q[COL_W-1:BEAT_W], low_col};
    end else begin : g_flat
      assign beat_col = low_col;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dir_q  <= DIR_RD;
      base_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= beat_fire && last_beat;
      err_q  <= cmd_valid && busy;
      if (!busy && cmd_valid) begin
        busy   <= 1'b1;
        dir_q  <= cmd_write ? DIR_WR : DIR_RD;
        base_q <= cmd_col;
        cnt_q  <= '0;
      end else if (beat_fire) begin
        cnt_q <= cnt_q + BEAT_W'(1);
        if (last_beat) busy <= 1'b0;
      end
    end
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cke_eff |=> $stable(cnt_q)) else $error("counter moved while suspended"); // R3

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> $stable(dir_q) && $stable(base_q)) else $error("command taken mid-burst"); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R8
endmodule

// File: rtl/sdr_word_store.sv
module sdr_word_store #(
  parameter int DATA_W = 32,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[col] <= wr_word;
    end
  end

  assign rd_word = mem_q[col];
endmodule

// File: rtl/sdr_read_stage.sv
module sdr_read_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_eff,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] word,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_en) begin
      rd_valid <= 1'b1;
      rd_data  <= word;
    end else if (cke_eff) begin
      rd_valid <= 1'b0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_eff |=> $stable(rd_data) && $stable(rd_valid)) else $error("read bus moved while suspended"); // R4
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
  import sdr_burst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int COL_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_in,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              burst_done,
  output logic              cmd_err
);
  logic             cke_eff;
  logic             busy;
  logic             beat_fire;
  burst_dir_e       beat_dir;
  logic [COL_W-1:0] beat_col;
  logic [DATA_W-1:0] store_word;
  logic             wr_en;
  logic             rd_en;

  sdr_cke_sync #(.RESET_LEVEL(1'b1)) u_cke (
    .clk(clk), .rst_n(rst_n), .cke_in(cke_in), .cke_eff(cke_eff)
  );

  sdr_burst_ctrl #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cke_eff(cke_eff),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .busy(busy), .beat_fire(beat_fire), .beat_dir(beat_dir),
    .beat_col(beat_col), .done_q(burst_done), .err_q(cmd_err)
  );

  assign wr_en     = beat_fire && (beat_dir == DIR_WR) && wr_valid;
  assign rd_en     = beat_fire && (beat_dir == DIR_RD);
  assign cmd_ready = !busy;

  sdr_word_store #(.DATA_W(DATA_W), .COL_W(COL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .col(beat_col),
    .wr_word(wr_data), .rd_word(store_word)
  );

  sdr_read_stage #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cke_eff(cke_eff), .rd_en(rd_en),
    .word(store_word), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_NO_WR_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cke_eff) else $error("write while suspended"); // R5

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> cmd_ready) else $error("still busy at done"); // R8
endmodule

// File: tb/sdr_burst_engine_tb.sv
`timescale 1ns/1ps
module sdr_burst_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke_in;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        cmd_write;
  logic [3:0]  cmd_col;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        burst_done;
  logic        cmd_err;

  int total = 0;
  int bad = 0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  sdr_burst_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cke_in(cke_in), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .burst_done(burst_done), .cmd_err(cmd_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] col_at(input logic [3:0] base, input int n);
    return {base[3:2], 2'(base[1:0] + 2'(n))};
  endfunction

  // pat bit s: enable level effective in slot s; vmask bit s: wr_valid in slot s
  task automatic run_write(input logic [3:0] base, input logic [7:0] pat, input logic [7:0] vmask, input logic [31:0] seed);
    int beats = 0;
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = base; cke_in = pat[0];
    tick();
    cmd_valid = 1'b0;
    check("R7", "ready low in burst", 32'(cmd_ready), 32'd0);
    for (int s = 0; s < 8 && beats < 4; s++) begin
      cke_in   = (s < 7) ? pat[s+1] : 1'b1;
      wr_data  = seed + 32'(s);
      wr_valid = vmask[s];
      tick();
      if (pat[s]) begin
        if (vmask[s]) model[col_at(base, beats)] = seed + 32'(s);
        beats++;
      end
      check("R8", "done in write", 32'(burst_done), 32'(beats == 4));
    end
    check("R8", "ready after write", 32'(cmd_ready), 32'd1);
    cke_in = 1'b1; wr_valid = 1'b0;
    tick();
    check("R8", "done single pulse", 32'(burst_done), 32'd0);
  endtask

  task automatic run_read(input logic [3:0] base, input logic [7:0] pat, input int err_slot);
    int beats = 0;
    logic [31:0] last = '0;
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = base; cke_in = pat[0];
    tick();
    cmd_valid = 1'b0;
    for (int s = 0; s < 8 && beats < 4; s++) begin
      cke_in = (s < 7) ? pat[s+1] : 1'b1;
      if (s == err_slot) begin
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 4'd0;
      end
      tick();
      cmd_valid = 1'b0;
      if (s == err_slot) check("R7", "error pulse", 32'(cmd_err), 32'd1);
      else               check("R7", "no error", 32'(cmd_err), 32'd0);
      if (pat[s]) begin
        last = model[col_at(base, beats)];
        check("R10", "read data", rd_data, last);
        check("R10", "read valid", 32'(rd_valid), 32'd1);
        beats++;
      end else if (beats > 0) begin
        check("R4", "held data", rd_data, last);
        check("R3", "held valid", 32'(rd_valid), 32'd1);
      end
      check("R8", "done in read", 32'(burst_done), 32'(beats == 4));
    end
    cke_in = 1'b1;
    tick();
    check("R8", "done single pulse", 32'(burst_done), 32'd0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    rst_n = 1'b0; cke_in = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_col = '0; wr_valid = 1'b0; wr_data = '0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1", "ready", 32'(cmd_ready), 32'd1);
    check("R1", "rd_valid", 32'(rd_valid), 32'd0);
    check("R1", "done", 32'(burst_done), 32'd0);
    check("R1", "err", 32'(cmd_err), 32'd0);
    run_read(4'd4, 8'hFF, -1);              // R1 zeros
    // R6 wrap write from column 5
    run_write(4'd5, 8'hFF, 8'hFF, 32'hA000_0000);
    run_read(4'd5, 8'hFF, -1);
    run_read(4'd4, 8'hFF, -1);
    // R2 R5 suspended write slots: pattern 1,0,1,1,0,1
    run_write(4'd8, 8'b0010_1101, 8'hFF, 32'hB000_0000);
    run_read(4'd8, 8'hFF, -1);
    // R3 R4 suspended read: 1,0,0,1,0,1,1
    run_read(4'd10, 8'b0110_1001, -1);
    run_read(4'd6, 8'b0111_1010, -1);
    // R9 wr_valid low on second beat
    run_write(4'd12, 8'hFF, 8'b1111_1101, 32'hC000_0000);
    run_read(4'd12, 8'hFF, -1);
    // R7 command while busy
    run_read(4'd9, 8'hFF, 1);
    run_read(4'd0, 8'hFF, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule